// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block turns a fast oscillator clock into the feedback pulse of a phase-locked loop, dividing by an integer plus a twelve-bit fraction. A dual-modulus prescaler counts oscillator edges in periods of 32 or 33. A swallow counter groups those periods into one reference cycle and picks the modulus of each period from the integer divide value. A fractional accumulator adds the fraction word once per cycle. When that addition carries, exactly one prescaler period of the next cycle is stretched to 33, so that cycle is one oscillator edge longer.

The integer value N is split as N = 32·P + S, where S is the low five bits and P the rest. Each cycle has P prescaler periods, and S of them use modulus 33. An overflow adds one more modulus-33 period, placed in the first modulus-32 slot. The running sum is exported so that an external twelve-bit converter can build a phase-error cancelling voltage. The integer and fraction inputs are only sampled at a cycle boundary.

Top module: `fracn_divider`

## Requirements
- R1: At each feedback pulse the sum word becomes (previous sum + fraction word) mod 4096, where the fraction word is the value present on the edge that produces the pulse. It then holds until the next pulse.
- R2: The overflow output is the carry out of the R1 addition. It changes only together with the feedback pulse and stays constant for the whole following cycle.
- R3: The number of oscillator edges from one feedback pulse to the next is N when the overflow output was 0 at the first of the two pulses, and N+1 when it was 1. This comes from exactly S + overflow prescaler periods of modulus 33.
- R4: Over any run of c consecutive cycles with a fixed N and fraction F, the total edge count is c·N + floor((s + c·F)/4096), where s is the sum word before the first of those additions.
- R5: A change of the integer or fraction input in the middle of a cycle does not alter that cycle. The new integer value sets the length of the cycle that starts at the next feedback pulse, and the new fraction is used in the addition at that pulse.
- R6: While reset is high, the sum word and overflow read 0 and the feedback pulse is low. The first cycle after reset is exactly N edges long, and its closing pulse loads the sum word with F.
- R7: With a fraction of 0 the overflow stays 0 and every cycle is exactly N edges.
- R8: The divider is exact over the whole supported range 1024 ≤ N ≤ 2^IW−1, including N = 1024 (S = 0) and N = 4095 (S = 31) for the default IW = 12.
- R9: The feedback pulse is high for exactly one oscillator clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| int_div | input | IW (12) | Integer divide value N; bits [4:0] give S, the upper bits give P |
| frac_word | input | FW (12) | Fraction added each cycle, in units of 1/4096 |
| fb_pulse | output | 1 | One-clock feedback pulse at the end of each divided cycle |
| sum_word | output | FW (12) | Accumulator sum for the phase-error converter |
| ovf | output | 1 | Carry of the latest accumulation; high marks a stretched cycle |

## Verification
A wrong accumulator value shows at the sum port on the very next feedback pulse. It then reaches the cycle length one cycle later, as a wrong N or N+1 interval. A prescaler modulus chosen wrongly in any single period moves the next feedback pulse by one edge, so the interval check catches it within the same cycle. A value latched at the wrong moment shows up as an old-length or new-length cycle appearing one cycle too early or too late around an input change. Long runs with fixed values compare the total edge count with the closed-form average, which exposes a lost or doubled carry that a single interval could hide.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  typedef enum logic {MOD32 = 1'b0, MOD33 = 1'b1} mod_e;
  localparam int PRE_BASE = 32;
  localparam int SW_W = 5;
endpackage

// File: rtl/fracn_prescaler.sv
module fracn_prescaler
  import fracn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  mod_e next_mod,
  output logic tick,
  output mod_e cur_mod
);
  localparam int CW = $clog2(PRE_BASE + 1);
  localparam logic [CW-1:0] LAST32 = CW'(PRE_BASE - 1);
  localparam logic [CW-1:0] LAST33 = CW'(PRE_BASE);

  logic [CW-1:0] pc;

  assign tick = (pc == ((cur_mod == MOD33) ? LAST33 : LAST32));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      cur_mod <= next_mod;
    end else if (tick) begin
      pc      <= '0;
      cur_mod <= next_mod;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  AST_MOD_HELD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cur_mod)); // R3
endmodule

// File: rtl/fracn_swallow.sv
module fracn_swallow
  import fracn_pkg::*;
#(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] int_div,
  input  logic          tick,
  input  mod_e          cur_mod,
  input  logic          carry_in,
  output mod_e          next_mod,
  output logic          cycle_end
);
  localparam int PW = IW - SW_W;

  logic [PW-1:0]   k_q, p_q, k_nx;
  logic [SW_W-1:0] s_q, s_nx;
  logic            ext_q, ext_nx, load;
  logic [SW_W:0]   n33_q;

  assign cycle_end = tick && (k_q == p_q - 1'b1);
  assign load      = rst || cycle_end;
  assign k_nx      = load ? '0 : k_q + 1'b1;
  assign s_nx      = load ? int_div[SW_W-1:0] : s_q;
  assign ext_nx    = load ? (!rst && carry_in) : ext_q;

  always_comb begin
    if (k_nx < PW'(s_nx))
      next_mod = MOD33;
    else if (ext_nx && (k_nx == PW'(s_nx)))
      next_mod = MOD33;
    else
      next_mod = MOD32;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      k_q   <= '0;
      p_q   <= int_div[IW-1:SW_W];
      s_q   <= int_div[SW_W-1:0];
      ext_q <= ext_nx;
      n33_q <= '0;
    end else if (tick) begin
      k_q   <= k_nx;
      n33_q <= n33_q + ((cur_mod == MOD33) ? 1'b1 : 1'b0);
    end
  end

  AST_STRETCH_COUNT: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> (n33_q + ((cur_mod == MOD33) ? 1'b1 : 1'b0)) ==
                  ({1'b0, s_q} + ext_q)); // R3
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [FW-1:0] frac,
  output logic [FW-1:0] sum,
  output logic          ovf,
  output logic          carry
);
  logic [FW:0] total;

  assign total = {1'b0, sum} + {1'b0, frac};
  assign carry = total[FW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
      ovf <= 1'b0;
    end else if (step) begin
      sum <= total[FW-1:0];
      ovf <= carry;
    end
  end

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sum)); // R1
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int IW = 12,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] int_div,
  input  logic [FW-1:0] frac_word,
  output logic          fb_pulse,
  output logic [FW-1:0] sum_word,
  output logic          ovf
);
  logic tick, cycle_end, carry;
  mod_e cur_mod, next_mod;

  fracn_prescaler u_pre (
    .clk      (clk),
    .rst      (rst),
    .next_mod (next_mod),
    .tick     (tick),
    .cur_mod  (cur_mod)
  );

  fracn_swallow #(.IW(IW)) u_swl (
    .clk       (clk),
    .rst       (rst),
    .int_div   (int_div),
    .tick      (tick),
    .cur_mod   (cur_mod),
    .carry_in  (carry),
    .next_mod  (next_mod),
    .cycle_end (cycle_end)
  );

  fracn_accum #(.FW(FW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .step  (cycle_end),
    .frac  (frac_word),
    .sum   (sum_word),
    .ovf   (ovf),
    .carry (carry)
  );

  always_ff @(posedge clk) begin
    if (rst) fb_pulse <= 1'b0;
    else     fb_pulse <= cycle_end;
  end

  AST_SUM_STEP: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> sum_word == FW'($past(sum_word) + $past(frac_word))); // R1
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |-> $stable(ovf)); // R2
  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R9
endmodule

// File: tb/fracn_divider_bench.sv
`timescale 1ns/1ps
module fracn_divider_bench;
  localparam int IW = 12;
  localparam int FW = 12;
  localparam int NV = 6;
  // columns: integer N, fraction F, measured cycles
  localparam int VN [NV] = '{1030, 1024, 4095, 1100, 2000, 1500};
  localparam int VF [NV] = '{1024,    0, 2048, 4095,    1, 3000};
  localparam int VC [NV] = '{   8,    4,    4,    6,    4,    6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] int_div = 12'd1030;
  logic [FW-1:0] frac_word = 12'd1024;
  logic fb_pulse, ovf;
  logic [FW-1:0] sum_word;

  int checks = 0, errors = 0, wide_err = 0;
  int model_sum = 0, cur_n = 1030, cur_ovf = 0, len = 0;

  always #2 clk = ~clk;

  fracn_divider #(.IW(IW), .FW(FW)) u_fracn_divider (
    .clk(clk), .rst(rst), .int_div(int_div), .frac_word(frac_word),
    .fb_pulse(fb_pulse), .sum_word(sum_word), .ovf(ovf)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_fb(input int start, output int n);
    int cnt = start;
    forever begin
      @(negedge clk);
      cnt++;
      if (fb_pulse) begin
        if (cnt == 1 && start == 0) wide_err++;
        n = cnt;
        return;
      end
      if (cnt > 6000) begin
        checks++; errors++;
        $display("FAIL R3 actual=timeout expected=pulse");
        finish_run();
      end
    end
  endtask

  // update the model at a pulse and compare the sum and overflow ports
  task automatic step_model(input int f);
    int t = model_sum + f;
    model_sum = t % 4096;
    cur_ovf = (t >= 4096) ? 1 : 0;
    check(sum_word == FW'(model_sum), "R1 sum", int'(sum_word), model_sum);
    check(ovf == cur_ovf[0], "R2 ovf", int'(ovf), cur_ovf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R6: reset state
    check(sum_word == 0, "R6 sum in reset", int'(sum_word), 0);
    check(ovf == 0, "R6 ovf in reset", int'(ovf), 0);
    check(fb_pulse == 0, "R6 pulse in reset", int'(fb_pulse), 0);
    rst = 1'b0;
    wait_fb(0, len);
    check(len == 1030, "R6 first cycle", len, 1030);
    step_model(1024);

    for (int v = 0; v < NV; v++) begin
      int s_pre, total, exp_total;
      string tag;
      int_div = IW'(VN[v]);
      frac_word = FW'(VF[v]);
      s_pre = model_sum;
      wait_fb(0, len);
      check(len == cur_n + cur_ovf, "R5 old length kept", len, cur_n + cur_ovf);
      step_model(VF[v]);
      cur_n = VN[v];
      total = 0;
      for (int c = 0; c < VC[v]; c++) begin
        wait_fb(0, len);
        check(len == cur_n + cur_ovf, "R3 cycle length", len, cur_n + cur_ovf);
        total += len;
        step_model(VF[v]);
      end
      exp_total = VC[v] * VN[v] + (s_pre + VC[v] * VF[v]) / 4096;
      if (VF[v] == 0) tag = "R7 zero fraction total";
      else if (VN[v] == 1024 || VN[v] == 4095) tag = "R8 range edge total";
      else tag = "R4 long-run total";
      check(total == exp_total, tag, total, exp_total);
    end

    // R5: change the integer value in the middle of a cycle
    repeat (100) @(negedge clk);
    int_div = 12'd1200;
    wait_fb(100, len);
    check(len == cur_n + cur_ovf, "R5 mid-cycle change", len, cur_n + cur_ovf);
    step_model(1500 == cur_n ? 3000 : int'(frac_word));
    cur_n = 1200;
    wait_fb(0, len);
    check(len == 1200 + cur_ovf, "R5 new length", len, 1200 + cur_ovf);
    step_model(int'(frac_word));

    // R6: reset in the middle of a run
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sum_word == 0, "R6 sum after mid reset", int'(sum_word), 0);
    check(ovf == 0, "R6 ovf after mid reset", int'(ovf), 0);
    rst = 1'b0;
    model_sum = 0;
    wait_fb(0, len);
    check(len == 1200, "R6 cycle after mid reset", len, 1200);
    check(sum_word == frac_word, "R6 sum loads fraction", int'(sum_word), int'(frac_word));

    check(wide_err == 0, "R9 pulse width", wide_err, 0);
    finish_run();
  end
endmodule